// File: doc/BRIEF.md
# DRAM Low-Power Mode Sequencer

This block sits on the controller side of a DDR2-style memory interface. It controls the clock-enable pin that moves the device into and out of its two low-power conditions. Self refresh is requested with a level signal and is entered only when every bank is closed. Power-down is requested with another level signal. It is entered whether or not a row is open, and the open-bank status at entry decides whether the device sits in precharge or active power-down. While the device is in a low-power state, and during the exit latency that follows, the sequencer forces the command bus to NOP. It also drops per-class ready flags, so the command scheduler holds its reads and its other commands until each is legal again.

The exit latency depends on the state being left. Leaving self refresh, reads wait a fixed read delay and all other commands wait a programmable delay. Leaving precharge power-down, both classes wait the programmable precharge exit delay. Leaving active power-down, they wait either the fast or the slow delay. A mode-register bit, sampled when power-down is entered, picks between the two. The programmable delays are captured while reset is asserted. A refresh-interval tick counts time spent in power-down, and the sequencer forces an exit before the allowed number of intervals is used up. Entry is held off while a mode-register access or a data transfer is in flight.

Top module: `lpm_seq`

## Requirements
- R1: While `rst_n` is low, the four delay inputs are captured; later changes to them have no effect. After reset, `cke`=1, `cmd_nop`=0, `rd_ready`=1 and `oth_ready`=1.
- R2: A high `sr_req` takes the device into self refresh (`cke` low on the next edge) only when `bank_open`=0. While `bank_open`=1, `cke` stays high. Self refresh lasts as long as `sr_req` stays high.
- R3: When `sr_req` falls in self refresh, the exit is registered at edge E (`cke` rises). `rd_ready` is high after edge E+SR_RD_DLY (default 200), provided `cfg_sr_exit` is no larger than that value.
- R4: After a self-refresh exit at edge E, `oth_ready` is high after edge E+max(`cfg_sr_exit`,1).
- R5: A high `pd_req` enters power-down on the next edge, whether `bank_open` is 0 or 1. If `sr_req` and `pd_req` are both high and `bank_open`=0, self refresh is chosen.
- R6: While `mrs_busy` or `xfer_busy` is high, neither low-power state is entered and `cke` stays high. Entry follows on the edge after both are low.
- R7: Power-down entered with `bank_open`=0 (precharge power-down) is left when `pd_req` falls. Both ready outputs rise after edge E+max(`cfg_pd_exit`,1).
- R8: In power-down entered with `bank_open`=1 (active power-down), the exit delay is max(`cfg_apd_fast`,1) if `mr_slow_exit` was 0 at the entry edge, or max(`cfg_apd_slow`,1) if it was 1. Changes to `mr_slow_exit` during power-down are ignored.
- R9: Power-down is limited to PD_MAX_REFI (default 9) refresh intervals. On the (PD_MAX_REFI-1)th `ref_tick` seen in power-down, the sequencer exits even though `pd_req` is high. It does not re-enter power-down until `pd_req` has been low for at least one edge.
- R10: `cmd_nop` is high, and both ready outputs are low, whenever `cke` is low. On the exit edge `cke` rises while `cmd_nop` stays high. `cmd_nop` stays high until `oth_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset; delay inputs are sampled while it is low |
| cfg_pd_exit | input | CNT_W | Precharge power-down exit delay in cycles |
| cfg_apd_fast | input | CNT_W | Fast active power-down exit delay in cycles |
| cfg_apd_slow | input | CNT_W | Slow active power-down exit delay in cycles |
| cfg_sr_exit | input | CNT_W | Self-refresh exit delay for non-read commands |
| mr_slow_exit | input | 1 | Mode-register exit-speed bit: 0 fast, 1 slow |
| sr_req | input | 1 | Level request to stay in self refresh |
| pd_req | input | 1 | Level request to stay in power-down |
| bank_open | input | 1 | High when any bank has an open row |
| mrs_busy | input | 1 | Mode-register command time still running |
| xfer_busy | input | 1 | Read or write data transfer in progress |
| ref_tick | input | 1 | One-cycle pulse per refresh interval |
| cke | output | 1 | Clock enable to the memory device |
| cmd_nop | output | 1 | Forces the command bus to NOP/deselect |
| rd_ready | output | 1 | Read-class commands may be issued |
| oth_ready | output | 1 | Non-read commands may be issued |

## Verification
The bench builds the block with its default parameters: an 8-bit delay width, the 200-cycle read delay after self refresh, and a 9-interval power-down limit. The short forced-exit window therefore takes only eight tick pulses. A sweep over delay values 0, 1, 2, 3 and 5 resets the block once per value. Each pass measures the cycle at which each ready flag rises after leaving precharge power-down, fast and slow active power-down, and self refresh. The zero setting reaches the one-cycle minimum, and the widest setting shows that reads and non-reads are released at different cycles. Directed passes cover held-off entry, the self-refresh priority, the mode bit changing during power-down, and the forced exit with its re-entry lockout.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_SR  = 2'd1,
        ST_PPD = 2'd2,
        ST_APD = 2'd3
    } lpm_state_e;

endpackage

// File: rtl/lpm_exit_timer.sv
module lpm_exit_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SR_RD_DLY   = 200,
    parameter int PD_MAX_REFI = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_pd_exit,
    input  logic [CNT_W-1:0] cfg_apd_fast,
    input  logic [CNT_W-1:0] cfg_apd_slow,
    input  logic [CNT_W-1:0] cfg_sr_exit,
    input  logic             mr_slow_exit,
    input  logic             sr_req,
    input  logic             pd_req,
    input  logic             bank_open,
    input  logic             mrs_busy,
    input  logic             xfer_busy,
    input  logic             ref_tick,
    output logic             cke,
    output logic             cmd_nop,
    output logic             rd_ready,
    output logic             oth_ready
);

    localparam int REFI_W      = $clog2(PD_MAX_REFI + 1);
    localparam int FORCE_TICKS = PD_MAX_REFI - 1;

    typedef struct packed {
        lpm_state_e        state;
        logic              cke;
        logic              slow;
        logic              pd_block;
        logic [REFI_W-1:0] refi;
        logic [CNT_W-1:0]  xp;
        logic [CNT_W-1:0]  xfast;
        logic [CNT_W-1:0]  xslow;
        logic [CNT_W-1:0]  xsr;
    } regs_t;

    regs_t r_d;
    regs_t r_q;

    logic             ld_rd;
    logic             ld_oth;
    logic [CNT_W-1:0] rd_val;
    logic [CNT_W-1:0] oth_val;
    logic             rd_zero;
    logic             oth_zero;
    logic             busy;
    logic             timers_idle;
    logic             pd_exit;
    logic [CNT_W-1:0] pd_dly;

    lpm_state_e        st_q;
    logic [REFI_W-1:0] refi_q;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    // Countdown for read-class commands, then for every other command.
    lpm_exit_timer #(.W(CNT_W)) u_rd_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld_rd),
        .val   (rd_val),
        .zero  (rd_zero)
    );

    lpm_exit_timer #(.W(CNT_W)) u_oth_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld_oth),
        .val   (oth_val),
        .zero  (oth_zero)
    );

    always_comb begin
        r_d         = r_q;
        ld_rd       = 1'b0;
        ld_oth      = 1'b0;
        rd_val      = '0;
        oth_val     = '0;
        busy        = mrs_busy | xfer_busy;
        timers_idle = rd_zero & oth_zero;
        pd_exit     = 1'b0;
        pd_dly      = r_q.xp;

        if (!pd_req) begin
            r_d.pd_block = 1'b0;
        end

        unique case (r_q.state)
            ST_RUN: begin
                if (sr_req && !bank_open && !busy && timers_idle) begin
                    r_d.state = ST_SR;
                    r_d.cke   = 1'b0;
                end else if (pd_req && !r_q.pd_block && !busy && timers_idle) begin
                    r_d.state = bank_open ? ST_APD : ST_PPD;
                    r_d.cke   = 1'b0;
                    r_d.slow  = mr_slow_exit;
                    r_d.refi  = '0;
                end
            end
            ST_SR: begin
                if (!sr_req) begin
                    r_d.state = ST_RUN;
                    r_d.cke   = 1'b1;
                    ld_rd     = 1'b1;
                    ld_oth    = 1'b1;
                    rd_val    = CNT_W'(SR_RD_DLY);
                    oth_val   = r_q.xsr;
                end
            end
            default: begin
                pd_exit = !pd_req ||
                          (ref_tick && (r_q.refi == REFI_W'(FORCE_TICKS - 1)));
                if (r_q.state == ST_APD) begin
                    pd_dly = r_q.slow ? r_q.xslow : r_q.xfast;
                end
                if (pd_exit) begin
                    r_d.state = ST_RUN;
                    r_d.cke   = 1'b1;
                    ld_rd     = 1'b1;
                    ld_oth    = 1'b1;
                    rd_val    = pd_dly;
                    oth_val   = pd_dly;
                    if (pd_req) begin
                        r_d.pd_block = 1'b1;
                    end
                end else if (ref_tick) begin
                    r_d.refi = r_q.refi + REFI_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= ST_RUN;
            r_q.cke      <= 1'b1;
            r_q.slow     <= 1'b0;
            r_q.pd_block <= 1'b0;
            r_q.refi     <= '0;
            r_q.xp       <= at_least_one(cfg_pd_exit);
            r_q.xfast    <= at_least_one(cfg_apd_fast);
            r_q.xslow    <= at_least_one(cfg_apd_slow);
            r_q.xsr      <= at_least_one(cfg_sr_exit);
        end else begin
            r_q <= r_d;
        end
    end

    assign st_q      = r_q.state;
    assign refi_q    = r_q.refi;
    assign cke       = r_q.cke;
    assign cmd_nop   = (r_q.state != ST_RUN) || !oth_zero;
    assign oth_ready = (r_q.state == ST_RUN) && oth_zero;
    assign rd_ready  = (r_q.state == ST_RUN) && oth_zero && rd_zero;

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk
    import lpm_pkg::*;
#(
    parameter int REFI_W      = 4,
    parameter int FORCE_TICKS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cmd_nop,
    input logic              rd_ready,
    input logic              oth_ready,
    input logic              sr_req,
    input logic              bank_open,
    input logic              mrs_busy,
    input logic              xfer_busy,
    input lpm_state_e        state,
    input logic [REFI_W-1:0] refi
);

    p_sr_bank_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SR && $past(state) == ST_RUN) |-> !$past(bank_open));

    p_sr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SR && sr_req) |=> (state == ST_SR && !cke));

    p_entry_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (!$past(mrs_busy) && !$past(xfer_busy)));

    p_lp_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd_nop && !rd_ready && !oth_ready));

    p_exit_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (cmd_nop && !oth_ready && !rd_ready));

    p_refi_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PPD || state == ST_APD) |-> (refi < REFI_W'(FORCE_TICKS)));

endmodule

bind lpm_seq lpm_seq_chk #(
    .REFI_W      (REFI_W),
    .FORCE_TICKS (FORCE_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cmd_nop   (cmd_nop),
    .rd_ready  (rd_ready),
    .oth_ready (oth_ready),
    .sr_req    (sr_req),
    .bank_open (bank_open),
    .mrs_busy  (mrs_busy),
    .xfer_busy (xfer_busy),
    .state     (st_q),
    .refi      (refi_q)
);

// File: tb/sim_lpm_seq.sv
module sim_lpm_seq;

    localparam int CNT_W = 8;
    localparam int SR_RD = 200;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cfg_pd_exit = '0;
    logic [CNT_W-1:0] cfg_apd_fast = '0;
    logic [CNT_W-1:0] cfg_apd_slow = '0;
    logic [CNT_W-1:0] cfg_sr_exit = '0;
    logic mr_slow_exit = 1'b0, sr_req = 1'b0, pd_req = 1'b0, bank_open = 1'b0;
    logic mrs_busy = 1'b0, xfer_busy = 1'b0, ref_tick = 1'b0;
    logic cke, cmd_nop, rd_ready, oth_ready;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lpm_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_pd_exit(cfg_pd_exit), .cfg_apd_fast(cfg_apd_fast),
        .cfg_apd_slow(cfg_apd_slow), .cfg_sr_exit(cfg_sr_exit),
        .mr_slow_exit(mr_slow_exit), .sr_req(sr_req), .pd_req(pd_req),
        .bank_open(bank_open), .mrs_busy(mrs_busy), .xfer_busy(xfer_busy),
        .ref_tick(ref_tick), .cke(cke), .cmd_nop(cmd_nop),
        .rd_ready(rd_ready), .oth_ready(oth_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Resets with given delays, then scrambles the delay inputs (R1).
    task automatic do_reset(input int xp, input int xf, input int xs, input int xsr);
        rst_n = 1'b0;
        cfg_pd_exit = CNT_W'(xp); cfg_apd_fast = CNT_W'(xf);
        cfg_apd_slow = CNT_W'(xs); cfg_sr_exit = CNT_W'(xsr);
        sr_req = 0; pd_req = 0; bank_open = 0; mrs_busy = 0; xfer_busy = 0;
        ref_tick = 0; mr_slow_exit = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cke == 1'b1, "R1 cke after reset", int'(cke), 1);
        chk(cmd_nop == 1'b0, "R1 cmd_nop after reset", int'(cmd_nop), 0);
        chk(rd_ready && oth_ready, "R1 ready after reset", int'({rd_ready, oth_ready}), 3);
        cfg_pd_exit = 8'hEE; cfg_apd_fast = 8'hEE; cfg_apd_slow = 8'hEE; cfg_sr_exit = 8'hEE;
    endtask

    // Counts negedges after an exit stimulus until each ready rises.
    task automatic wait_ready(output int t_oth, output int t_rd);
        t_oth = -1;
        t_rd = -1;
        for (int i = 1; i <= 400; i++) begin
            @(negedge clk);
            ref_tick = 1'b0;
            if (i == 1) begin
                chk(cke == 1'b1, "R10 cke high on exit", int'(cke), 1);
                chk(cmd_nop == 1'b1, "R10 nop on exit", int'(cmd_nop), 1);
            end
            if (t_oth < 0 && oth_ready) t_oth = i;
            if (t_rd < 0 && rd_ready) t_rd = i;
            if (t_oth > 0 && t_rd > 0) break;
        end
    endtask

    task automatic check_entered(input string tag);
        chk(cke == 1'b0, tag, int'(cke), 0);
        chk(cmd_nop && !rd_ready && !oth_ready, "R10 nop and not ready while low",
            int'({cmd_nop, rd_ready, oth_ready}), 4);
    endtask

    task automatic enter_pd(input bit open, input bit slow);
        bank_open = open;
        mr_slow_exit = slow;
        pd_req = 1'b1;
        @(negedge clk);
        check_entered("R5 power-down entry");
        mr_slow_exit = ~slow;
        repeat (3) @(negedge clk);
        chk(cke == 1'b0, "R5 stays in power-down", int'(cke), 0);
    endtask

    task automatic leave_pd(input int exp, input string tag);
        int to, tr;
        pd_req = 1'b0;
        wait_ready(to, tr);
        chk(to == exp, tag, to, exp);
        chk(tr == exp, tag, tr, exp);
    endtask

    task automatic sr_cycle(input int xsr, input string tag);
        int to, tr;
        sr_req = 1'b0;
        pd_req = 1'b0;
        wait_ready(to, tr);
        chk(to == eff(xsr) + 1, {tag, " R4 non-read delay"}, to, eff(xsr) + 1);
        chk(tr == SR_RD + 1, {tag, " R3 read delay"}, tr, SR_RD + 1);
    endtask

    initial begin
        int vals[5] = '{0, 1, 2, 3, 5};
        foreach (vals[k]) begin
            int d;
            d = vals[k];
            do_reset(d, d + 1, d + 4, d + 2);
            enter_pd(1'b0, 1'b0);
            leave_pd(eff(d) + 1, "R7 precharge exit delay");
            enter_pd(1'b1, 1'b0);
            leave_pd(d + 2, "R8 fast active exit delay");
            enter_pd(1'b1, 1'b1);
            leave_pd(d + 5, "R8 slow active exit delay");
            bank_open = 1'b0;
            sr_req = 1'b1;
            @(negedge clk);
            check_entered("R2 self-refresh entry");
            repeat (5) @(negedge clk);
            chk(cke == 1'b0, "R2 stays in self refresh", int'(cke), 0);
            sr_cycle(d + 2, "sweep");
        end

        // Directed: bank open holds off self refresh.
        do_reset(2, 3, 6, 4);
        bank_open = 1'b1;
        sr_req = 1'b1;
        begin
            bit stayed = 1'b1;
            repeat (3) begin
                @(negedge clk);
                if (!cke) stayed = 1'b0;
            end
            chk(stayed, "R2 held off with bank open", int'(stayed), 1);
        end
        bank_open = 1'b0;
        @(negedge clk);
        check_entered("R2 entry after bank closes");
        bank_open = 1'b1;
        @(negedge clk);
        sr_cycle(4, "bank");
        bank_open = 1'b0;

        // Directed: busy flags hold off entry.
        mrs_busy = 1'b1;
        pd_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(cke == 1'b1, "R6 mode-register busy blocks entry", int'(cke), 1);
        mrs_busy = 1'b0;
        xfer_busy = 1'b1;
        repeat (3) @(negedge clk);
        chk(cke == 1'b1, "R6 transfer busy blocks entry", int'(cke), 1);
        xfer_busy = 1'b0;
        @(negedge clk);
        check_entered("R6 entry after busy clears");
        leave_pd(3, "R6 exit after busy entry");
        xfer_busy = 1'b1;
        sr_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(cke == 1'b1, "R6 transfer busy blocks self refresh", int'(cke), 1);
        xfer_busy = 1'b0;
        @(negedge clk);
        check_entered("R6 self refresh after busy clears");
        sr_cycle(4, "busy");

        // Directed: self refresh wins over power-down.
        sr_req = 1'b1;
        pd_req = 1'b1;
        @(negedge clk);
        check_entered("R5 priority entry");
        sr_cycle(4, "R5 priority");

        // Directed: forced exit from power-down and lockout.
        enter_pd(1'b0, 1'b0);
        for (int t = 0; t < 7; t++) begin
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
            @(negedge clk);
        end
        chk(cke == 1'b0, "R9 still in power-down after 7 ticks", int'(cke), 0);
        ref_tick = 1'b1;
        begin
            int to, tr;
            bit stayed = 1'b1;
            wait_ready(to, tr);
            chk(to == 3, "R9 forced exit delay", to, 3);
            repeat (5) begin
                @(negedge clk);
                if (!cke) stayed = 1'b0;
            end
            chk(stayed, "R9 no re-entry while request held", int'(stayed), 1);
        end
        pd_req = 1'b0;
        @(negedge clk);
        pd_req = 1'b1;
        @(negedge clk);
        check_entered("R9 re-entry after request dropped");
        leave_pd(3, "R9 exit after re-entry");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule